// File: doc/BRIEF.md
# Function-Coded 32-bit Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit. It takes two 32-bit operands and a 5-bit function code and returns a 32-bit result plus four status flags: negative, overflow, carry and zero. A single adder/subtractor serves addition, subtraction and both magnitude comparisons. A barrel shifter and a Boolean unit cover the remaining operations. An output multiplexer selects among the three units from the class bits of the code.

The function code is packed as `{sub, sel[1:0], shft, math}`, with `sub` in bit 4 and `math` in bit 0.

| Bits `{shft, math}` | Class | How the other bits are used |
|---|---|---|
| 01 | Arithmetic | `sub` picks add or subtract |
| 11 | Comparison | `sel[0]` picks signed or unsigned |
| 10 | Shift | `sel` picks the shift kind |
| 00 | Boolean | `sel` picks the Boolean function |

The shift amount always comes from the low five bits of operand A. The value shifted is operand B.

The block is meant to sit in the execute stage of a simple processor datapath. Operand selection, register access and clocking belong to the surrounding logic.

Top module: `alu_fn32`

## Requirements
- R1: With `{shft,math}=01` and `sub=0`, the result is A+B. The carry flag is the carry out of bit 31. The overflow flag is set when A and B have the same sign and the sum's sign differs from it.
- R2: With `{shft,math}=01` and `sub=1`, the result is A-B, computed as A+~B+1. The carry flag is 1 when no borrow occurs, so A==B gives carry=1 and zero=1.
- R3: With `{shft,math}=11` and `sel[0]=0`, the result has bit 0 equal to the signed A<B and bits 31..1 zero. The answer is correct even when the subtraction overflows.
- R4: With `{shft,math}=11` and `sel[0]=1`, the result has bit 0 equal to the unsigned A<B, which is the inverse of the subtraction carry. Bits 31..1 are zero.
- R5: The comparison class always subtracts, whatever the `sub` bit holds. Bit `sel[1]` is a don't-care in the arithmetic and comparison classes.
- R6: With `{shft,math}=10` and `sel[1]=0`, the result is B shifted left, with zero fill. This covers both `sel=00` and `sel=01`.
- R7: With `{shft,math}=10` and `sel=10`, the result is B shifted right, with zero fill.
- R8: With `{shft,math}=10` and `sel=11`, the result is B shifted right, filled with copies of B[31].
- R9: The shift amount is A[4:0]. Bits A[31:5] have no effect on a shift result.
- R10: With `{shft,math}=00`, `sel` values 00, 01, 10 and 11 give A AND B, A OR B, A XOR B and A NOR B.
- R11: The zero flag is 1 exactly when all 32 result bits are 0, for every code.
- R12: For every code, the negative, overflow and carry flags report the adder's result. The adder subtracts when `sub=1` or the class is comparison, and adds otherwise. Negative is bit 31 of the adder sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A; its low five bits also give the shift amount |
| b_i | input | 32 | Operand B; it is the value that gets shifted |
| fn_i | input | 5 | Function code `{sub, sel[1:0], shft, math}` |
| result_o | output | 32 | Selected result |
| neg_o | output | 1 | Adder sum bit 31 |
| ovf_o | output | 1 | Signed overflow of the adder |
| carry_o | output | 1 | Carry out of the adder (1 means no borrow when subtracting) |
| zero_o | output | 1 | Result is all zeros |

## Verification
The assertions embedded in the units check several behaviours on every evaluation:
- subtracting equal operands yields zero with carry set;
- a zero shift amount passes B through unchanged;
- an arithmetic right shift of a negative value keeps the sign bit;
- XOR agrees with the AND/OR identity;
- both comparison outputs match the true signed and unsigned ordering.

Other behaviours can only be shown by the bench's scenarios, where a reference model is compared with the result and all four flags:
- the class decoding, including the don't-care code bits;
- the overflow and carry boundaries at 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF;
- the fact that A[31:5] is ignored when shifting;
- the flag values reported for non-arithmetic codes.

// File: rtl/alu_fn_pkg.sv
package alu_fn_pkg;
  localparam int FN_W = 5;

  typedef struct packed {
    logic       sub;
    logic [1:0] sel;
    logic       shft;
    logic       math;
  } alu_fn_t;

  typedef enum logic [1:0] {
    CLS_BOOL  = 2'b00,
    CLS_ARITH = 2'b01,
    CLS_SHIFT = 2'b10,
    CLS_CMP   = 2'b11
  } alu_cls_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         neg_o,
  output logic         ovf_o,
  output logic         carry_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    full    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    sum_o   = full[W-1:0];
    carry_o = full[W];
    neg_o   = full[W-1];
    // same-sign inputs, different-sign sum
    ovf_o   = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
  end

  // R2
  always_comb begin
    if (sub_i && (a_i == b_i)) begin
      sub_equal_chk: assert ((sum_o == '0) && carry_o)
        else $error("R2 equal subtract not zero/no-borrow");
    end
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   data_i,
  input  logic [SHW-1:0] amt_i,
  input  logic           right_i,
  input  logic           arith_i,
  output logic [W-1:0]   res_o
);
  logic         fill;
  logic [W-1:0] rev_in;
  logic [W-1:0] stage [SHW+1];

  always_comb begin
    fill = right_i & arith_i & data_i[W-1];
    for (int i = 0; i < W; i++) begin
      rev_in[i] = right_i ? data_i[i] : data_i[W-1-i];
    end
  end

  assign stage[0] = rev_in;

  // left shifts reuse the right-shift network on bit-reversed data
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 2 ** k;
    assign stage[k+1] = amt_i[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      res_o[i] = right_i ? stage[SHW][i] : stage[SHW][W-1-i];
    end
  end

  // R9
  always_comb begin
    if (amt_i == '0) begin
      zero_amt_chk: assert (res_o == data_i)
        else $error("R9 zero shift amount altered data");
    end
  end

  // R8
  always_comb begin
    if (right_i && arith_i && data_i[W-1]) begin
      sign_keep_chk: assert (res_o[W-1])
        else $error("R8 arithmetic shift lost sign");
    end
  end
endmodule

// File: rtl/alu_bool.sv
module alu_bool #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      2'b00:   res_o = a_i & b_i;
      2'b01:   res_o = a_i | b_i;
      2'b10:   res_o = a_i ^ b_i;
      default: res_o = ~(a_i | b_i);
    endcase
  end

  // R10
  always_comb begin
    if (sel_i == 2'b10) begin
      xor_ident_chk: assert (res_o == ((a_i | b_i) & ~(a_i & b_i)))
        else $error("R10 xor identity broken");
    end
  end
endmodule

// File: rtl/alu_fn32.sv
module alu_fn32
  import alu_fn_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [FN_W-1:0] fn_i,
  output logic [W-1:0]    result_o,
  output logic            neg_o,
  output logic            ovf_o,
  output logic            carry_o,
  output logic            zero_o
);
  alu_fn_t      fn;
  alu_cls_e     cls;
  logic         sub_eff;
  logic         lt_s;
  logic         lt_u;
  logic [W-1:0] sum;
  logic [W-1:0] sh_res;
  logic [W-1:0] bl_res;

  always_comb begin
    fn      = alu_fn_t'(fn_i);
    cls     = alu_cls_e'({fn.shft, fn.math});
    // comparisons always subtract
    sub_eff = fn.sub | (cls == CLS_CMP);
  end

  alu_addsub #(.W(W)) u_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (sub_eff),
    .sum_o   (sum),
    .neg_o   (neg_o),
    .ovf_o   (ovf_o),
    .carry_o (carry_o)
  );

  alu_shift #(.W(W), .SHW(SHW)) u_shift (
    .data_i  (b_i),
    .amt_i   (a_i[SHW-1:0]),
    .right_i (fn.sel[1]),
    .arith_i (fn.sel[0]),
    .res_o   (sh_res)
  );

  alu_bool #(.W(W)) u_bool (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (fn.sel),
    .res_o (bl_res)
  );

  always_comb begin
    lt_s = neg_o ^ ovf_o;
    lt_u = ~carry_o;
    unique case (cls)
      CLS_ARITH: result_o = sum;
      CLS_CMP:   result_o = {{(W-1){1'b0}}, fn.sel[0] ? lt_u : lt_s};
      CLS_SHIFT: result_o = sh_res;
      default:   result_o = bl_res;
    endcase
    zero_o = ~|result_o;
  end

  // R3
  always_comb begin
    if (cls == CLS_CMP && !fn.sel[0]) begin
      signed_lt_chk: assert (result_o[0] == ($signed(a_i) < $signed(b_i)))
        else $error("R3 signed compare wrong");
    end
  end

  // R4
  always_comb begin
    if (cls == CLS_CMP && fn.sel[0]) begin
      unsigned_lt_chk: assert (result_o[0] == (a_i < b_i))
        else $error("R4 unsigned compare wrong");
    end
  end
endmodule

// File: tb/alu_fn32_bench.sv
module alu_fn32_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [31:0] a, b, res;
  logic [4:0]  fn;
  logic        n, v, c, z;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  alu_fn32 u_alu_fn32 (
    .a_i(a), .b_i(b), .fn_i(fn), .result_o(res),
    .neg_o(n), .ovf_o(v), .carry_o(c), .zero_o(z)
  );

  typedef struct {
    logic [31:0] res;
    logic        n, v, c, z;
    string       tag;
  } item_t;

  item_t q[$];

  function automatic item_t model(input logic [31:0] ma, mb, input logic [4:0] mf, input string tag);
    item_t       it;
    logic        sub_e;
    logic [31:0] bb;
    logic [32:0] s;
    sub_e = mf[4] | (mf[1] & mf[0]);
    bb    = sub_e ? ~mb : mb;
    s     = {1'b0, ma} + {1'b0, bb} + {32'd0, sub_e};
    it.n  = s[31];
    it.c  = s[32];
    it.v  = (ma[31] == bb[31]) && (s[31] != ma[31]);
    case (mf[1:0])
      2'b01: it.res = mf[4] ? ma - mb : ma + mb;
      2'b11: it.res = mf[2] ? {31'd0, ma < mb} : {31'd0, $signed(ma) < $signed(mb)};
      2'b10: case (mf[3:2])
               2'b10:   it.res = mb >> ma[4:0];
               2'b11:   it.res = $unsigned($signed(mb) >>> ma[4:0]);
               default: it.res = mb << ma[4:0];
             endcase
      default: case (mf[3:2])
               2'b00:   it.res = ma & mb;
               2'b01:   it.res = ma | mb;
               2'b10:   it.res = ma ^ mb;
               default: it.res = ~(ma | mb);
             endcase
    endcase
    it.z   = (it.res == 32'd0);
    it.tag = tag;
    return it;
  endfunction

  function automatic string tag_of(input logic [4:0] mf);
    case (mf[1:0])
      2'b01:   return mf[4] ? "R2" : "R1";
      2'b11:   return mf[2] ? "R4" : "R3";
      2'b10:   return mf[3] ? (mf[2] ? "R8" : "R7") : "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic drive(input logic [31:0] da, db, input logic [4:0] df, input string tag);
    @(posedge clk);
    a  = da;
    b  = db;
    fn = df;
    q.push_back(model(da, db, df, tag));
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if (res !== e.res) begin
        errors++;
        $display("FAIL %s result fn=%b a=%h b=%h actual=%h expected=%h", e.tag, fn, a, b, res, e.res);
      end
      checks++;
      if (z !== e.z) begin
        errors++;
        $display("FAIL R11 zero fn=%b actual=%b expected=%b", fn, z, e.z);
      end
      checks++;
      if ({n, v, c} !== {e.n, e.v, e.c}) begin
        errors++;
        $display("FAIL R12 flags nvc fn=%b a=%h b=%h actual=%b expected=%b", fn, a, b, {n, v, c}, {e.n, e.v, e.c});
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_ni = 1'b0;
    a = '0; b = '0; fn = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state inputs: AND of zeros
    drive(32'h0, 32'h0, 5'b00000, "R10");
    // R1 add: plain, signed overflow, carry wrap to zero
    drive(32'd5, 32'd7, 5'b00001, "R1");
    drive(32'h7fffffff, 32'd1, 5'b00001, "R1");
    drive(32'hffffffff, 32'd1, 5'b01001, "R1");
    // R2 subtract: equal, borrow, overflow
    drive(32'h1234, 32'h1234, 5'b10001, "R2");
    drive(32'd1, 32'd2, 5'b11101, "R2");
    drive(32'h80000000, 32'd1, 5'b10001, "R2");
    // R3 signed compare, including overflowing subtraction
    drive(32'hffffffff, 32'd1, 5'b10011, "R3");
    drive(32'h80000000, 32'h7fffffff, 5'b10011, "R3");
    drive(32'h7fffffff, 32'h80000000, 5'b11011, "R3");
    drive(32'd9, 32'd9, 5'b10011, "R3");
    // R4 unsigned compare
    drive(32'hffffffff, 32'd1, 5'b10111, "R4");
    drive(32'd1, 32'hffffffff, 5'b11111, "R4");
    // R5 compare with sub bit clear still subtracts
    drive(32'd3, 32'd4, 5'b00011, "R5");
    drive(32'd4, 32'd3, 5'b00111, "R5");
    // R6 left shift, both sel encodings
    drive(32'd4, 32'h0000_00f1, 5'b00010, "R6");
    drive(32'd31, 32'h3, 5'b00110, "R6");
    // R7 / R8 right shifts of a negative value
    drive(32'd8, 32'hf000_0000, 5'b01010, "R7");
    drive(32'd8, 32'hf000_0000, 5'b01110, "R8");
    drive(32'd31, 32'h8000_0000, 5'b01110, "R8");
    // R9 upper bits of A ignored; zero amount
    drive(32'hffff_ffe1, 32'h8000_0001, 5'b01010, "R9");
    drive(32'hffff_ffe0, 32'hdead_beef, 5'b01110, "R9");
    // R10 Boolean set
    drive(32'hf0f0_ff00, 32'hff00_f0f0, 5'b00000, "R10");
    drive(32'hf0f0_ff00, 32'hff00_f0f0, 5'b00100, "R10");
    drive(32'hf0f0_ff00, 32'hff00_f0f0, 5'b01000, "R10");
    drive(32'hf0f0_ff00, 32'hff00_f0f0, 5'b01100, "R10");
    drive(32'hffff_ffff, 32'h0, 5'b01100, "R11");
    // mixed patterns over every code
    for (int i = 0; i < 4000; i++) begin
      logic [4:0]  rf;
      logic [31:0] ra, rb;
      rf = 5'($urandom);
      ra = $urandom;
      rb = (i % 5 == 0) ? ra : $urandom;
      if (i % 7 == 0) ra = ra & 32'h0000_003f;
      drive(ra, rb, rf, tag_of(rf));
    end
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    finish_run();
  end
endmodule